// File: doc/BRIEF.md
# Serial Configuration Front End for a Fractional-N Synthesizer

This block receives configuration words for a PLL synthesizer over a three-wire serial link made of a shift clock, a data line and a load strobe. The serial inputs are sampled on the system clock. Each rising edge of the shift clock moves one data bit into a 24-bit shift register, least significant bit first. A rising edge of the strobe decodes the two address bits at the top of the word and copies the word's fields into working registers. The main divider, the reference divider and the fractional logic read these registers as parallel outputs.

One word sets the main divider. It carries the integer ratio, the fractional increment and the modulus select. A second word sets the reference ratio, the charge-pump ratio bit, the lock-output mode, the software power-down bit and the fractional compensation DAC code. A third word holds test bits. The DAC code does not take effect when its word arrives. It is held in a staging register and becomes active together with the next main-divider word, so both change at the same moment.

The block also produces an enable for the synthesizer. The enable combines a hardware pin and the software bit, and the pin can invert the polarity of the software bit. A speed-up output drives the charge pumps during the strobe pulse that loads a new main ratio. A test bit can hold this output on permanently.

Top module: `synth_prog_if`

## Requirements
- R1: On each rising edge of `ser_clk_i` seen while `ser_strobe_i` is low, `ser_data_i` enters the shift register at bit 23 and every stored bit moves down by one. After 24 such edges, the first bit sent sits at bit 0 and the address sits in bits 23:22.
- R2: Address 00 is the main word: bit 21 is the modulus-5 select, bits 18:16 are the fractional increment and bits 15:0 are N. Address 01 is the reference word: bits 21:12 are R, bit 11 is the lock open-drain mode, bit 10 is PD, bit 9 is the charge-pump ratio bit and bits 8:1 are the DAC code. Address 11 is the test word. Address 10 changes no output.
- R3: While `ser_strobe_i` is high, the shift clock is ignored and the shift register keeps its contents. The word is decoded once, on the strobe's rising edge.
- R4: A DAC code from a reference word goes into a staging register, and `fc_dac_o` does not change. The staged code reaches `fc_dac_o` only when a main word is loaded.
- R5: After a main word is loaded, `speedup_o` is high for the rest of that strobe pulse and goes low once the strobe is low. Loading a reference word does not raise it.
- R6: Bit 15 of the test word, when set, holds `speedup_o` high regardless of the strobe.
- R7: `synth_en_o` equals `pon_i` XOR PD. With `pon_i` = 0 the synthesizer is enabled when PD = 1.
- R8: A loaded N below 512 is stored as 512. A loaded R below 4 is stored as 4.
- R9: After reset the outputs take these defaults: N = 8752, increment = 2, modulus-5 select = 0, R = 81, charge-pump bit = 0, lock mode = 0, PD = 0, DAC code = 80, and the test bit = 0.
- R10: Words of any length are accepted. Only the last 24 bits shifted in before the strobe rises are decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_data_i | input | 1 | Serial data, least significant bit first |
| ser_strobe_i | input | 1 | Load strobe, active high |
| pon_i | input | 1 | Hardware power control pin |
| main_n_o | output | 16 | Integer main divider ratio |
| frac_inc_o | output | 3 | Fractional accumulator increment |
| frac_mod5_o | output | 1 | 1 selects modulo 5, 0 selects modulo 8 |
| ref_r_o | output | 10 | Reference divider ratio |
| cp_ratio_o | output | 1 | Charge-pump current ratio select |
| lock_od_o | output | 1 | Lock output open-drain mode |
| fc_dac_o | output | 8 | Active fractional compensation DAC code |
| synth_en_o | output | 1 | Effective synthesizer enable |
| speedup_o | output | 1 | Charge-pump speed-up control |

## Verification
A decode or field-position fault shows up at the parallel outputs within about two system clocks of the strobe's rising edge, so each word is compared once the strobe pulse is over. Faults in the staging register stay hidden until the next main word copies the code out. The bench therefore loads reference and main words alternately and compares `fc_dac_o` each time. A shift clock that leaks through while the strobe is high changes nothing visible until the same shift register is strobed again, so that case is checked by re-strobing without new data. A speed-up flag that never clears appears as `speedup_o` stuck high after the strobe falls.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

    localparam int WORD_W  = 24;
    localparam int ADDR_W  = 2;
    localparam int N_W     = 16;
    localparam int NF_W    = 3;
    localparam int R_W     = 10;
    localparam int FC_W    = 8;
    localparam int N_MIN   = 512;
    localparam int R_MIN   = 4;
    localparam int TSU_BIT = 15;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_MAIN = 2'b00,
        ADDR_REF  = 2'b01,
        ADDR_NONE = 2'b10,
        ADDR_TEST = 2'b11
    } word_addr_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              mod5;
        logic [1:0]        spare;
        logic [NF_W-1:0]   nf;
        logic [N_W-1:0]    n;
    } main_word_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [R_W-1:0]    r;
        logic              lock_od;
        logic              pd;
        logic              cp;
        logic [FC_W-1:0]   fc;
        logic              spare;
    } ref_word_t;

    typedef struct packed {
        logic [N_W-1:0]  n;
        logic [NF_W-1:0] nf;
        logic            mod5;
        logic [R_W-1:0]  r;
        logic            lock_od;
        logic            pd;
        logic            cp;
        logic [FC_W-1:0] fc;
        logic [FC_W-1:0] fc_stage;
        logic            test_su;
        logic            su;
    } cfg_t;

    localparam logic [N_W-1:0]  DEF_N  = N_W'(8752);
    localparam logic [NF_W-1:0] DEF_NF = NF_W'(2);
    localparam logic [R_W-1:0]  DEF_R  = R_W'(81);
    localparam logic [FC_W-1:0] DEF_FC = FC_W'(80);

    localparam cfg_t CFG_RESET = '{
        n:        DEF_N,
        nf:       DEF_NF,
        mod5:     1'b0,
        r:        DEF_R,
        lock_od:  1'b0,
        pd:       1'b0,
        cp:       1'b0,
        fc:       DEF_FC,
        fc_stage: DEF_FC,
        test_su:  1'b0,
        su:       1'b0
    };

endpackage

// File: rtl/synth_prog_edges.sv
module synth_prog_edges (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sclk_i,
    input  logic strobe_i,
    output logic shift_o,
    output logic load_o
);

    typedef struct packed {
        logic sclk;
        logic stb;
    } edge_t;

    edge_t edge_d, edge_q;

    always_comb begin
        edge_d.sclk = sclk_i;
        edge_d.stb  = strobe_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) edge_q <= '0;
        else         edge_q <= edge_d;
    end

    assign shift_o = sclk_i & ~edge_q.sclk & ~strobe_i;
    assign load_o  = strobe_i & ~edge_q.stb;

endmodule

// File: rtl/synth_prog_shifter.sv
module synth_prog_shifter #(
    parameter int WIDTH = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             shift_i,
    input  logic             data_i,
    output logic [WIDTH-1:0] word_o
);

    logic [WIDTH-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (shift_i) sr_d = {data_i, sr_q[WIDTH-1:1]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= sr_d;
    end

    assign word_o = sr_q;

endmodule

// File: rtl/synth_prog_regbank.sv
module synth_prog_regbank
    import synth_prog_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              strobe_i,
    input  logic [WORD_W-1:0] word_i,
    output cfg_t              cfg_o,
    output logic              main_load_o
);

    cfg_t       cfg_d, cfg_q;
    main_word_t mw;
    ref_word_t  rw;
    word_addr_e addr;

    function automatic logic [N_W-1:0] floor_n(input logic [N_W-1:0] v);
        return (v < N_W'(N_MIN)) ? N_W'(N_MIN) : v;
    endfunction

    function automatic logic [R_W-1:0] floor_r(input logic [R_W-1:0] v);
        return (v < R_W'(R_MIN)) ? R_W'(R_MIN) : v;
    endfunction

    always_comb begin
        mw    = main_word_t'(word_i);
        rw    = ref_word_t'(word_i);
        addr  = word_addr_e'(word_i[WORD_W-1 -: ADDR_W]);
        cfg_d = cfg_q;
        if (!strobe_i) cfg_d.su = 1'b0;
        if (load_i) begin
            case (addr)
                ADDR_MAIN: begin
                    cfg_d.n    = floor_n(mw.n);
                    cfg_d.nf   = mw.nf;
                    cfg_d.mod5 = mw.mod5;
                    cfg_d.fc   = cfg_q.fc_stage;
                    cfg_d.su   = 1'b1;
                end
                ADDR_REF: begin
                    cfg_d.r        = floor_r(rw.r);
                    cfg_d.lock_od  = rw.lock_od;
                    cfg_d.pd       = rw.pd;
                    cfg_d.cp       = rw.cp;
                    cfg_d.fc_stage = rw.fc;
                end
                ADDR_TEST: cfg_d.test_su = word_i[TSU_BIT];
                default:   cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= CFG_RESET;
        else         cfg_q <= cfg_d;
    end

    assign cfg_o       = cfg_q;
    assign main_load_o = load_i & (addr == ADDR_MAIN);

endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
    import synth_prog_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            ser_clk_i,
    input  logic            ser_data_i,
    input  logic            ser_strobe_i,
    input  logic            pon_i,
    output logic [N_W-1:0]  main_n_o,
    output logic [NF_W-1:0] frac_inc_o,
    output logic            frac_mod5_o,
    output logic [R_W-1:0]  ref_r_o,
    output logic            cp_ratio_o,
    output logic            lock_od_o,
    output logic [FC_W-1:0] fc_dac_o,
    output logic            synth_en_o,
    output logic            speedup_o
);

    logic              shift_pulse;
    logic              load_pulse;
    logic              main_load;
    logic [WORD_W-1:0] sr_word;
    cfg_t              cfg;

    synth_prog_edges i_edges (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sclk_i   (ser_clk_i),
        .strobe_i (ser_strobe_i),
        .shift_o  (shift_pulse),
        .load_o   (load_pulse)
    );

    synth_prog_shifter #(.WIDTH(WORD_W)) i_shifter (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .shift_i (shift_pulse),
        .data_i  (ser_data_i),
        .word_o  (sr_word)
    );

    synth_prog_regbank i_regbank (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (load_pulse),
        .strobe_i    (ser_strobe_i),
        .word_i      (sr_word),
        .cfg_o       (cfg),
        .main_load_o (main_load)
    );

    assign main_n_o    = cfg.n;
    assign frac_inc_o  = cfg.nf;
    assign frac_mod5_o = cfg.mod5;
    assign ref_r_o     = cfg.r;
    assign cp_ratio_o  = cfg.cp;
    assign lock_od_o   = cfg.lock_od;
    assign fc_dac_o    = cfg.fc;
    assign synth_en_o  = pon_i ^ cfg.pd;
    assign speedup_o   = cfg.su | cfg.test_su;

endmodule

// File: rtl/synth_prog_chk.sv
module synth_prog_chk
    import synth_prog_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              strobe_i,
    input logic [WORD_W-1:0] sr_word,
    input logic              main_load,
    input logic              test_su,
    input logic              speedup,
    input logic [N_W-1:0]    main_n,
    input logic [R_W-1:0]    ref_r,
    input logic [FC_W-1:0]   fc_dac
);

    assert_shift_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_i |=> $stable(sr_word));

    assert_fc_only_on_main_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(fc_dac) |-> $past(main_load));

    assert_su_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        main_load |=> speedup);

    assert_su_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!strobe_i && !test_su) |=> !speedup);

    assert_n_floor_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        main_n >= N_W'(N_MIN));

    assert_r_floor_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ref_r >= R_W'(R_MIN));

endmodule

bind synth_prog_if synth_prog_chk i_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (ser_strobe_i),
    .sr_word   (sr_word),
    .main_load (main_load),
    .test_su   (cfg.test_su),
    .speedup   (speedup_o),
    .main_n    (main_n_o),
    .ref_r     (ref_r_o),
    .fc_dac    (fc_dac_o)
);

// File: tb/test_synth_prog_if.sv
module test_synth_prog_if;
    import synth_prog_pkg::*;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, sdata = 1'b0, strobe = 1'b0, pon = 1'b0;
    logic [15:0] main_n;
    logic [2:0]  frac_inc;
    logic        frac_mod5, cp_ratio, lock_od, synth_en, speedup;
    logic [9:0]  ref_r;
    logic [7:0]  fc_dac;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    synth_prog_if i_synth_prog_if (
        .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_data_i(sdata),
        .ser_strobe_i(strobe), .pon_i(pon), .main_n_o(main_n),
        .frac_inc_o(frac_inc), .frac_mod5_o(frac_mod5), .ref_r_o(ref_r),
        .cp_ratio_o(cp_ratio), .lock_od_o(lock_od), .fc_dac_o(fc_dac),
        .synth_en_o(synth_en), .speedup_o(speedup)
    );

    typedef struct packed {
        logic [23:0] word;
        logic [15:0] n;
        logic [2:0]  nf;
        logic        fm;
        logic [9:0]  r;
        logic        cp;
        logic        lk;
        logic        pd;
        logic [7:0]  fc;
        logic        tsu;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{{2'b01, 10'd100, 1'b1, 1'b1, 1'b1, 8'd200, 1'b0}, 16'd8752, 3'd2, 1'b0, 10'd100, 1'b1, 1'b1, 1'b1, 8'd80, 1'b0},
        '{{2'b00, 1'b1, 2'b00, 3'd3, 16'd1000}, 16'd1000, 3'd3, 1'b1, 10'd100, 1'b1, 1'b1, 1'b1, 8'd200, 1'b0},
        '{{2'b00, 1'b0, 2'b00, 3'd7, 16'd100}, 16'd512, 3'd7, 1'b0, 10'd100, 1'b1, 1'b1, 1'b1, 8'd200, 1'b0},
        '{{2'b01, 10'd2, 1'b0, 1'b0, 1'b0, 8'd17, 1'b0}, 16'd512, 3'd7, 1'b0, 10'd4, 1'b0, 1'b0, 1'b0, 8'd200, 1'b0},
        '{{2'b11, 6'd0, 1'b1, 15'd0}, 16'd512, 3'd7, 1'b0, 10'd4, 1'b0, 1'b0, 1'b0, 8'd200, 1'b1},
        '{{2'b00, 1'b0, 2'b00, 3'd0, 16'd65535}, 16'd65535, 3'd0, 1'b0, 10'd4, 1'b0, 1'b0, 1'b0, 8'd17, 1'b1},
        '{{2'b10, 22'h3FFFFF}, 16'd65535, 3'd0, 1'b0, 10'd4, 1'b0, 1'b0, 1'b0, 8'd17, 1'b1},
        '{{2'b11, 6'd0, 1'b0, 15'd0}, 16'd65535, 3'd0, 1'b0, 10'd4, 1'b0, 1'b0, 1'b0, 8'd17, 1'b0},
        '{{2'b00, 1'b1, 2'b00, 3'd5, 16'd512}, 16'd512, 3'd5, 1'b1, 10'd4, 1'b0, 1'b0, 1'b0, 8'd17, 1'b0},
        '{{2'b01, 10'd1023, 1'b0, 1'b1, 1'b0, 8'd255, 1'b0}, 16'd512, 3'd5, 1'b1, 10'd1023, 1'b0, 1'b0, 1'b1, 8'd17, 1'b0}
    };

    function automatic logic [41:0] snap();
        return {main_n, frac_inc, frac_mod5, ref_r, cp_ratio, lock_od, synth_en, fc_dac, speedup};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] v, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk); sdata = v[i]; sclk = 1'b1;
            @(negedge clk);
            @(negedge clk); sclk = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic pulse(output logic su_high, input int toggles, input logic tdata);
        @(negedge clk); strobe = 1'b1;
        repeat (3) @(negedge clk);
        su_high = speedup;
        for (int i = 0; i < toggles; i++) begin
            @(negedge clk); sdata = tdata; sclk = 1'b1;
            @(negedge clk); sclk = 1'b0;
        end
        @(negedge clk); strobe = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic su;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R9 reset defaults
        check("R9 reset", 64'(snap()),
              64'({16'd8752, 3'd2, 1'b0, 10'd81, 1'b0, 1'b0, 1'b0, 8'd80, 1'b0}));

        // R1 R2 R4 R6 R8 vector walk
        for (int v = 0; v < NV; v++) begin
            send_bits(32'(VECS[v].word), 24);
            pulse(su, 0, 1'b0);
            check($sformatf("R2 vector %0d", v), 64'(snap()),
                  64'({VECS[v].n, VECS[v].nf, VECS[v].fm, VECS[v].r, VECS[v].cp,
                       VECS[v].lk, VECS[v].pd, VECS[v].fc, VECS[v].tsu}));
        end

        // R7 pon inverts software bit (pd now 1)
        check("R7 pon0 pd1", 64'(synth_en), 64'(1));
        pon = 1'b1; @(negedge clk);
        check("R7 pon1 pd1", 64'(synth_en), 64'(0));
        pon = 1'b0; @(negedge clk);

        // R5 speed-up during main-word strobe, cleared after
        send_bits(32'({2'b00, 1'b0, 2'b00, 3'd1, 16'd2000}), 24);
        pulse(su, 0, 1'b0);
        check("R5 su high in strobe", 64'(su), 64'(1));
        check("R5 su low after strobe", 64'(speedup), 64'(0));
        check("R4 staged code applied", 64'(fc_dac), 64'(255));
        send_bits(32'({2'b01, 10'd50, 1'b0, 1'b1, 1'b0, 8'd9, 1'b0}), 24);
        pulse(su, 0, 1'b0);
        check("R5 no su for ref word", 64'(su), 64'(0));
        check("R4 ref word keeps code", 64'(fc_dac), 64'(255));

        // R3 shift clock ignored while strobe high
        send_bits(32'({2'b00, 1'b1, 2'b00, 3'd5, 16'd1234}), 24);
        pulse(su, 8, 1'b0);
        check("R3 first load", 64'(main_n), 64'(1234));
        pulse(su, 0, 1'b0);
        check("R3 reload same word", 64'(main_n), 64'(1234));
        check("R4 second main load", 64'(fc_dac), 64'(9));

        // R10 long word, last 24 bits decoded
        send_bits(32'h3F, 6);
        send_bits(32'({2'b00, 1'b0, 2'b00, 3'd1, 16'd3000}), 24);
        pulse(su, 0, 1'b0);
        check("R10 long word N", 64'(main_n), 64'(3000));
        check("R10 long word inc", 64'(frac_inc), 64'(1));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule